// File: doc/BRIEF.md
# Framed-Header SPI Host Controller

This block is an SPI master for a coprocessor that signals pending data on an interrupt line and gates every transfer behind a five-byte header exchange. Every transaction opens by lowering chip select and clocking out a header whose first byte names the operation. The following four bytes are zero. The five bytes shifted back in tell the master whether the slave is ready, how much space it has for a write, and how many bytes it holds for a read. The master then either moves the payload or closes the transaction at once. Chip select stays low from the first header bit to the last payload bit.

Reads are started by the interrupt input. Received bytes leave on a byte stream (`rx_valid`/`rx_data`). Each read ends with a one-cycle `rx_done` that carries the number of bytes delivered. Writes are requested by a one-cycle `wr_req` that carries the total length. Payload bytes are pulled from a look-ahead byte stream, one `wr_take` strobe per byte. A write that the slave refuses is retried back to back until it succeeds or a timeout expires. The final outcome is reported on `wr_done`/`wr_status`. A separate request pulses the coprocessor's active-low reset and then holds off all transfers for a settling time.

Top module: `hdr_spi_host`

## Requirements
- R1: SPI uses mode 0, most significant bit first. A read header is 0x0B followed by four 0x00 bytes. A write header is 0x0A followed by four 0x00 bytes.
- R2: `spi_csn` is low for the whole header and payload of a transaction. It returns high when the transaction ends, including when the header refuses the transfer.
- R3: The slave counts as ready only when the first reply byte is 0x02. A read with any other first byte delivers no bytes and reports `rx_len` = 0.
- R4: A read's byte count is reply byte 4 (high) concatenated with reply byte 3 (low), with bytes counted from 0. The count is limited to RX_CAP, and zero means no payload. Each payload byte is clocked while 0xFF is sent on MOSI. `rx_done` reports the delivered count.
- R5: A write sends its payload in stream order, with one `wr_take` per byte, only when the slave is ready and reply byte 1 (free space) is at least the length. Status codes are 0 for success, 1 for not ready and 2 for no space.
- R6: A refused write is retried until it succeeds. Once TIMEOUT_CYC cycles have passed since the request, the next refusal ends the write with that refusal's status.
- R7: A rising edge on `dev_irq` starts a read, even for a short pulse. Reads keep repeating while `dev_irq` stays high.
- R8: While a write is pending, interrupt edges are ignored. When a write request and an interrupt arrive in the same cycle, the write goes first.
- R9: A `rst_req` drives `dev_rst_n` low for RST_CYC cycles. It then holds `spi_csn` high for at least RST_CYC more cycles before any transfer starts.
- R10: After reset, `spi_csn` = 1, `spi_sclk` = 0 and `dev_rst_n` = 1, and no done or valid strobe is active.
- R11: SCLK is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |
| spi_csn | output | 1 | Chip select, active low |
| dev_irq | input | 1 | Slave data-pending interrupt |
| dev_rst_n | output | 1 | Slave reset, active low |
| rst_req | input | 1 | Pulse: reset the slave |
| wr_req | input | 1 | Pulse: start a write |
| wr_len | input | 8 | Write payload length, sampled with wr_req |
| wr_data | input | 8 | Current write stream byte |
| wr_take | output | 1 | Write stream byte consumed |
| wr_done | output | 1 | Write finished |
| wr_status | output | 2 | Write outcome code |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| rx_done | output | 1 | Read finished |
| rx_len | output | 16 | Bytes delivered by the read |

## Verification
The bench raises the interrupt and a write request on the same clock edge. The order in which the two operations then reach the bus shows the priority. The opcode of each header is logged as the slave model receives it. The first logged header must be the write, followed by the read that the still-high interrupt demands. A second scenario pulses the interrupt while a write is being retried. It is judged by the absence of any read header after the write completes.

// File: rtl/hsh_pkg.sv
package hsh_pkg;
    localparam int HDR_BYTES = 5;
    localparam logic [7:0] OPC_READ  = 8'h0B;
    localparam logic [7:0] OPC_WRITE = 8'h0A;
    localparam logic [7:0] SLV_READY = 8'h02;
    localparam logic [7:0] RD_FILL   = 8'hFF;

    typedef enum logic [1:0] {
        WST_OK        = 2'd0,
        WST_NOT_READY = 2'd1,
        WST_NO_SPACE  = 2'd2
    } wr_stat_e;

    typedef enum logic {OP_RD, OP_WR} op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RST_LOW, ST_RST_WAIT, ST_HDR, ST_PAY, ST_GAP
    } seq_st_e;

    // header reply bytes the sequencer keeps before the final byte arrives
    typedef struct packed {
        logic [7:0] status;
        logic [7:0] space;
        logic [7:0] cnt_lo;
    } hdr_info_t;

    function automatic logic [15:0] clamp_len(logic [15:0] avail, logic [15:0] cap);
        return (avail > cap) ? cap : avail;
    endfunction
endpackage

// File: rtl/hsh_irq_sync.sv
module hsh_irq_sync (
    input  logic clk,
    input  logic rst,
    input  logic irq_in,
    output logic irq_hi,
    output logic irq_rise
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], irq_in};
    end

    assign irq_hi   = sync_q[1];
    assign irq_rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/hsh_byte_engine.sv
module hsh_byte_engine #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; sclk <= 1'b0; done <= 1'b0;
            cnt <= '0; bit_idx <= '0; tx_sh <= '0; rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1; sclk <= 1'b0; cnt <= '0; bit_idx <= '0;
                tx_sh <= tx_byte;
            end else if (busy) begin
                if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign mosi = busy & tx_sh[7];
endmodule

// File: rtl/hsh_seq.sv
module hsh_seq
    import hsh_pkg::*;
#(
    parameter int RX_CAP      = 128,
    parameter int RST_CYC     = 1000,
    parameter int GAP_CYC     = 8,
    parameter int TIMEOUT_CYC = 20_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_hi,
    input  logic        irq_rise,
    input  logic        rst_req,
    input  logic        wr_req,
    input  logic [7:0]  wr_len,
    input  logic [7:0]  wr_data,
    input  logic        eng_done,
    input  logic [7:0]  eng_rx,
    output logic        eng_start,
    output logic [7:0]  eng_tx,
    output logic        csn,
    output logic        dev_rst_n,
    output logic        wr_take,
    output logic        wr_done,
    output wr_stat_e    wr_status,
    output logic        rx_valid,
    output logic [7:0]  rx_data,
    output logic        rx_done,
    output logic [15:0] rx_len
);
    localparam int TMR_W = $clog2(RST_CYC + GAP_CYC + 2);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 2);

    seq_st_e    st;
    op_e        op;
    hdr_info_t  info;
    logic [2:0] hdr_idx;
    logic [15:0] pay_len, pay_cnt;
    logic [7:0] wr_len_q;
    logic [TMR_W-1:0] tmr;
    logic [TO_W-1:0]  to_cnt;
    logic wr_pend, rd_edge, rst_pend;
    logic timed_out;
    logic [15:0] avail;

    assign timed_out = (to_cnt >= TO_W'(TIMEOUT_CYC));
    assign avail     = clamp_len({eng_rx, info.cnt_lo}, 16'(RX_CAP));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; op <= OP_RD; info <= '0; hdr_idx <= '0;
            pay_len <= '0; pay_cnt <= '0; wr_len_q <= '0; tmr <= '0; to_cnt <= '0;
            wr_pend <= 1'b0; rd_edge <= 1'b0; rst_pend <= 1'b0;
            eng_start <= 1'b0; eng_tx <= '0; csn <= 1'b1; dev_rst_n <= 1'b1;
            wr_take <= 1'b0; wr_done <= 1'b0; wr_status <= WST_OK;
            rx_valid <= 1'b0; rx_data <= '0; rx_done <= 1'b0; rx_len <= '0;
        end else begin
            eng_start <= 1'b0; wr_take <= 1'b0; wr_done <= 1'b0;
            rx_valid  <= 1'b0; rx_done <= 1'b0;
            if (rst_req) rst_pend <= 1'b1;
            if (wr_req && !wr_pend) begin
                wr_pend <= 1'b1; wr_len_q <= wr_len; to_cnt <= '0;
            end else if (wr_pend && !timed_out) begin
                to_cnt <= to_cnt + TO_W'(1);
            end
            // interrupt edges are only remembered outside a write
            if (irq_rise && !wr_pend) rd_edge <= 1'b1;

            case (st)
                ST_IDLE: begin
                    csn <= 1'b1;
                    if (rst_pend) begin
                        rst_pend <= 1'b0; dev_rst_n <= 1'b0; tmr <= '0; st <= ST_RST_LOW;
                    end else if (wr_pend || rd_edge || irq_hi) begin
                        op      <= wr_pend ? OP_WR : OP_RD;
                        rd_edge <= wr_pend ? rd_edge : 1'b0;
                        eng_tx  <= wr_pend ? OPC_WRITE : OPC_READ;
                        csn <= 1'b0; hdr_idx <= '0; eng_start <= 1'b1; st <= ST_HDR;
                    end
                end
                ST_RST_LOW: begin
                    if (tmr == TMR_W'(RST_CYC - 1)) begin
                        dev_rst_n <= 1'b1; tmr <= '0; st <= ST_RST_WAIT;
                    end else tmr <= tmr + TMR_W'(1);
                end
                ST_RST_WAIT: begin
                    if (tmr == TMR_W'(RST_CYC - 1)) st <= ST_IDLE;
                    else tmr <= tmr + TMR_W'(1);
                end
                ST_HDR: if (eng_done) begin
                    if (hdr_idx != 3'd4) begin
                        if (hdr_idx == 3'd0) info.status <= eng_rx;
                        if (hdr_idx == 3'd1) info.space  <= eng_rx;
                        if (hdr_idx == 3'd3) info.cnt_lo <= eng_rx;
                        hdr_idx <= hdr_idx + 3'd1;
                        eng_tx <= 8'h00; eng_start <= 1'b1;
                    end else begin
                        pay_cnt <= '0; tmr <= '0;
                        if (op == OP_RD) begin
                            if (info.status == SLV_READY && avail != 16'd0) begin
                                pay_len <= avail; eng_tx <= RD_FILL; eng_start <= 1'b1;
                                st <= ST_PAY;
                            end else begin
                                rx_done <= 1'b1; rx_len <= '0; csn <= 1'b1; st <= ST_GAP;
                            end
                        end else if (info.status == SLV_READY && info.space >= wr_len_q) begin
                            if (wr_len_q == 8'd0) begin
                                wr_done <= 1'b1; wr_status <= WST_OK; wr_pend <= 1'b0;
                                csn <= 1'b1; st <= ST_GAP;
                            end else begin
                                pay_len <= {8'd0, wr_len_q}; eng_tx <= wr_data;
                                wr_take <= 1'b1; eng_start <= 1'b1; st <= ST_PAY;
                            end
                        end else begin
                            if (timed_out) begin
                                wr_done <= 1'b1; wr_pend <= 1'b0;
                                wr_status <= (info.status != SLV_READY) ? WST_NOT_READY
                                                                        : WST_NO_SPACE;
                            end
                            csn <= 1'b1; st <= ST_GAP;
                        end
                    end
                end
                ST_PAY: if (eng_done) begin
                    pay_cnt <= pay_cnt + 16'd1;
                    if (op == OP_RD) begin
                        rx_valid <= 1'b1; rx_data <= eng_rx;
                    end
                    if (pay_cnt + 16'd1 == pay_len) begin
                        if (op == OP_RD) begin
                            rx_done <= 1'b1; rx_len <= pay_len;
                        end else begin
                            wr_done <= 1'b1; wr_status <= WST_OK; wr_pend <= 1'b0;
                        end
                        csn <= 1'b1; tmr <= '0; st <= ST_GAP;
                    end else begin
                        eng_tx    <= (op == OP_RD) ? RD_FILL : wr_data;
                        wr_take   <= (op == OP_WR);
                        eng_start <= 1'b1;
                    end
                end
                ST_GAP: begin
                    csn <= 1'b1;
                    if (tmr == TMR_W'(GAP_CYC - 1)) st <= ST_IDLE;
                    else tmr <= tmr + TMR_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hdr_spi_host.sv
module hdr_spi_host
    import hsh_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int RX_CAP      = 128,
    parameter int RST_CYC     = 1000,
    parameter int GAP_CYC     = 8,
    parameter int TIMEOUT_CYC = 20_000_000
) (
    input  logic        clk,
    input  logic        rst,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_csn,
    input  logic        dev_irq,
    output logic        dev_rst_n,
    input  logic        rst_req,
    input  logic        wr_req,
    input  logic [7:0]  wr_len,
    input  logic [7:0]  wr_data,
    output logic        wr_take,
    output logic        wr_done,
    output logic [1:0]  wr_status,
    output logic        rx_valid,
    output logic [7:0]  rx_data,
    output logic        rx_done,
    output logic [15:0] rx_len
);
    logic irq_hi, irq_rise;
    logic eng_start, eng_done, eng_busy;
    logic [7:0] eng_tx, eng_rx;
    wr_stat_e seq_status;

    hsh_irq_sync u_irq (
        .clk(clk), .rst(rst), .irq_in(dev_irq), .irq_hi(irq_hi), .irq_rise(irq_rise)
    );

    hsh_byte_engine #(.DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst(rst), .start(eng_start), .tx_byte(eng_tx), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx)
    );

    hsh_seq #(
        .RX_CAP(RX_CAP), .RST_CYC(RST_CYC), .GAP_CYC(GAP_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .irq_hi(irq_hi), .irq_rise(irq_rise), .rst_req(rst_req),
        .wr_req(wr_req), .wr_len(wr_len), .wr_data(wr_data), .eng_done(eng_done),
        .eng_rx(eng_rx), .eng_start(eng_start), .eng_tx(eng_tx), .csn(spi_csn),
        .dev_rst_n(dev_rst_n), .wr_take(wr_take), .wr_done(wr_done), .wr_status(seq_status),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_done(rx_done), .rx_len(rx_len)
    );

    assign wr_status = seq_status;
endmodule

// File: rtl/hsh_chk.sv
module hsh_chk #(
    parameter int RX_CAP = 128
) (
    input logic        clk,
    input logic        rst,
    input logic        spi_csn,
    input logic        spi_sclk,
    input logic        dev_rst_n,
    input logic        eng_busy,
    input logic        wr_done,
    input logic [1:0]  wr_status,
    input logic        rx_done,
    input logic [15:0] rx_len
);
    AST_CS_LOW_IN_BYTE: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !spi_csn); // R2
    AST_CS_RISE_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_csn) |-> !eng_busy); // R2
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> !spi_sclk); // R11
    AST_NO_XFER_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !dev_rst_n |-> spi_csn); // R9
    AST_RX_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (rx_len <= 16'(RX_CAP))); // R4
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> (wr_status != 2'd3)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !wr_done); // R6
endmodule

bind hdr_spi_host hsh_chk #(.RX_CAP(RX_CAP)) u_chk (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sclk(spi_sclk), .dev_rst_n(dev_rst_n),
    .eng_busy(eng_busy), .wr_done(wr_done), .wr_status(wr_status),
    .rx_done(rx_done), .rx_len(rx_len)
);

// File: tb/test_hdr_spi_host.sv
module test_hdr_spi_host;
    localparam int DIV = 2, CAP = 16, RSTC = 40, GAP = 4, TMO = 3000;

    logic clk = 1'b0, rst = 1'b1;
    logic spi_sclk, spi_mosi, spi_miso, spi_csn, dev_rst_n;
    logic dev_irq = 1'b0, rst_req = 1'b0, wr_req = 1'b0;
    logic [7:0] wr_len = '0, wr_data;
    logic wr_take, wr_done, rx_valid, rx_done;
    logic [1:0] wr_status;
    logic [7:0] rx_data;
    logic [15:0] rx_len;

    always #2.5 clk = ~clk;

    hdr_spi_host #(.CLK_DIV(DIV), .RX_CAP(CAP), .RST_CYC(RSTC), .GAP_CYC(GAP),
                   .TIMEOUT_CYC(TMO)) i_hdr_spi_host (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_csn(spi_csn), .dev_irq(dev_irq), .dev_rst_n(dev_rst_n), .rst_req(rst_req),
        .wr_req(wr_req), .wr_len(wr_len), .wr_data(wr_data), .wr_take(wr_take),
        .wr_done(wr_done), .wr_status(wr_status), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_done(rx_done), .rx_len(rx_len)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    // ---------------- slave model (mode 0) ----------------
    int fail_left = 0, s_idx = 0, s_bit = 0, n_rd = 0, n_wr = 0, hdr_bad = 0, fill_bad = 0;
    int op_n = 0, wcap_n = 0;
    logic [7:0] s_status = 8'h02, s_space = 8'h00, s_in = 8'h00, s_op = 8'h00;
    logic [15:0] s_avail = 16'h0;
    logic [7:0] op_log [0:255];
    logic [7:0] wcap [0:63];

    function automatic logic [7:0] sbyte(int i, logic [7:0] stv, logic [7:0] spc, logic [15:0] av);
        case (i)
            0: return stv;
            1: return spc;
            2: return 8'h00;
            3: return av[7:0];
            4: return av[15:8];
            default: return 8'h30 + 8'(i - 5);
        endcase
    endfunction

    logic [7:0] s_cur;
    assign s_cur    = sbyte(s_idx, s_status, s_space, s_avail);
    assign spi_miso = spi_csn ? 1'b0 : s_cur[3'd7 - 3'(s_bit)];

    always @(negedge spi_csn or posedge spi_sclk) begin
        if (!spi_sclk) begin
            s_idx = 0; s_bit = 0;
            if (fail_left > 0) begin s_status = 8'h00; fail_left = fail_left - 1; end
            else s_status = 8'h02;
        end else if (!spi_csn) begin
            s_in = {s_in[6:0], spi_mosi};
            s_bit = s_bit + 1;
            if (s_bit == 8) begin
                if (s_idx == 0) begin
                    s_op = s_in; op_log[op_n[7:0]] = s_in; op_n = op_n + 1;
                    if (s_in == 8'h0B) n_rd = n_rd + 1;
                    if (s_in == 8'h0A) n_wr = n_wr + 1;
                end else if (s_idx < 5) begin
                    if (s_in != 8'h00) hdr_bad = hdr_bad + 1;
                end else if (s_op == 8'h0B) begin
                    if (s_in != 8'hFF) fill_bad = fill_bad + 1;
                end else if (wcap_n < 64) begin
                    wcap[wcap_n] = s_in; wcap_n = wcap_n + 1;
                end
                s_idx = s_idx + 1; s_bit = 0;
            end
        end
    end

    // ---------------- write stream and monitors ----------------
    logic [7:0] wr_mem [0:63];
    int wr_k = 0, rx_n = 0, rxd_cnt = 0, wrd_cnt = 0, wrd_cyc = 0;
    logic [7:0] rx_buf [0:63];
    logic [15:0] last_rx_len = '0;
    logic [1:0] last_st = '0;
    assign wr_data = wr_mem[wr_k[5:0]];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wr_take) wr_k = wr_k + 1;
        if (rx_valid) begin
            if (rx_n < 64) rx_buf[rx_n] = rx_data;
            rx_n = rx_n + 1;
        end
        if (rx_done) begin rxd_cnt = rxd_cnt + 1; last_rx_len = rx_len; end
        if (wr_done) begin wrd_cnt = wrd_cnt + 1; last_st = wr_status; wrd_cyc = cyc; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wait_rx(input int target);
        while (rxd_cnt < target) @(negedge clk);
    endtask

    task automatic wait_wr(input int target);
        while (wrd_cnt < target) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk(spi_csn == 1'b1, "R10 csn", int'(spi_csn), 1);
        chk(spi_sclk == 1'b0, "R10 sclk", int'(spi_sclk), 0);
        chk(dev_rst_n == 1'b1, "R10 dev_rst_n", int'(dev_rst_n), 1);
        chk(!wr_done && !rx_valid && !rx_done, "R10 strobes", int'(wr_done | rx_valid | rx_done), 0);
    endtask

    task automatic t_dev_reset();
        int low_n = 0, wait_n = 0, r0 = rxd_cnt;
        s_avail = 16'd1;
        @(negedge clk) rst_req = 1'b1;
        @(negedge clk) rst_req = 1'b0;
        while (dev_rst_n) @(negedge clk);
        dev_irq = 1'b1; // read wanted during reset
        while (!dev_rst_n) begin low_n++; @(negedge clk); end
        while (spi_csn) begin wait_n++; @(negedge clk); end
        chk(low_n == RSTC, "R9 low width", low_n, RSTC);
        chk(wait_n >= RSTC, "R9 settle", wait_n, RSTC);
        wait_rx(r0 + 1);
        dev_irq = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_read(input logic [15:0] av, input int fails, input int exp_len, input string tag);
        int r0 = rxd_cnt, n0 = n_rd, ok = 1;
        s_avail = av; fail_left = fails; rx_n = 0; fill_bad = 0; hdr_bad = 0;
        @(negedge clk) dev_irq = 1'b1;
        repeat (3) @(negedge clk);
        dev_irq = 1'b0;
        wait_rx(r0 + 1);
        repeat (40) @(negedge clk);
        chk(last_rx_len == 16'(exp_len), tag, int'(last_rx_len), exp_len);
        chk(rx_n == exp_len, tag, rx_n, exp_len);
        for (int i = 0; i < exp_len; i++) if (rx_buf[i] != 8'h30 + 8'(i)) ok = 0;
        chk(ok == 1, tag, ok, 1);
        chk(n_rd - n0 == 1, "R7 one read per pulse", n_rd - n0, 1);
        chk(fill_bad == 0 && hdr_bad == 0, "R1/R4 mosi bytes", fill_bad + hdr_bad, 0);
    endtask

    task automatic t_write(input int len, input logic [7:0] space, input int fails,
                           input int exp_st, input string tag, output int attempts, output int took);
        int w0 = wrd_cnt, h0 = n_wr, c0, ok = 1;
        for (int i = 0; i < 64; i++) wr_mem[i] = 8'hA0 + 8'(i) + 8'(len);
        wr_k = 0; wcap_n = 0; hdr_bad = 0; s_space = space; fail_left = fails;
        @(negedge clk) begin wr_req = 1'b1; wr_len = 8'(len); end
        c0 = cyc;
        @(negedge clk) wr_req = 1'b0;
        wait_wr(w0 + 1);
        took = wrd_cyc - c0; attempts = n_wr - h0;
        repeat (20) @(negedge clk);
        chk(int'(last_st) == exp_st, tag, int'(last_st), exp_st);
        if (exp_st == 0) begin
            chk(wcap_n == len && wr_k == len, "R5 payload count", wcap_n, len);
            for (int i = 0; i < len; i++) if (wcap[i] != wr_mem[i]) ok = 0;
            chk(ok == 1, "R5 payload order", ok, 1);
        end else begin
            chk(wcap_n == 0 && wr_k == 0, "R5 no payload on refusal", wcap_n + wr_k, 0);
        end
        chk(hdr_bad == 0, "R1 write header zeros", hdr_bad, 0);
    endtask

    task automatic t_read_repeat();
        int r0 = rxd_cnt, n0 = n_rd;
        s_avail = 16'd2; fail_left = 0; rx_n = 0;
        @(negedge clk) dev_irq = 1'b1;
        wait_rx(r0 + 2);
        dev_irq = 1'b0;
        repeat (60) @(negedge clk);
        chk(n_rd - n0 == 2, "R7 repeat while high", n_rd - n0, 2);
        chk(rx_n == 4, "R7 repeat bytes", rx_n, 4);
    endtask

    task automatic t_collide();
        int o0 = op_n, w0 = wrd_cnt, r0 = rxd_cnt;
        s_avail = 16'd1; s_space = 8'd8; fail_left = 0; wr_k = 0;
        @(negedge clk) begin wr_req = 1'b1; wr_len = 8'd2; dev_irq = 1'b1; end
        @(negedge clk) wr_req = 1'b0;
        wait_wr(w0 + 1);
        wait_rx(r0 + 1);
        dev_irq = 1'b0;
        repeat (60) @(negedge clk);
        chk(op_log[o0[7:0]] == 8'h0A, "R8 write first", int'(op_log[o0[7:0]]), 'h0A);
        chk(op_log[8'(o0 + 1)] == 8'h0B, "R8 read after", int'(op_log[8'(o0 + 1)]), 'h0B);
    endtask

    task automatic t_masked();
        int w0 = wrd_cnt, n0 = n_rd;
        s_space = 8'd8; fail_left = 4; wr_k = 0;
        @(negedge clk) begin wr_req = 1'b1; wr_len = 8'd1; end
        @(negedge clk) wr_req = 1'b0;
        while (spi_csn) @(negedge clk);
        dev_irq = 1'b1;
        repeat (4) @(negedge clk);
        dev_irq = 1'b0;
        wait_wr(w0 + 1);
        repeat (300) @(negedge clk);
        chk(n_rd == n0, "R8 edge masked during write", n_rd - n0, 0);
        chk(last_st == 2'd0, "R6 retry then ok", int'(last_st), 0);
    endtask

    initial begin
        int att, took;
        repeat (4) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_dev_reset();
        t_read(16'd3, 0, 3, "R4 basic read");
        t_read(16'h0105, 0, CAP, "R4 clamp to capacity");
        t_read(16'd0, 0, 0, "R4 zero count");
        t_read(16'd3, 1, 0, "R3 not ready read");
        t_read_repeat();
        t_write(4, 8'd10, 0, 0, "R5 write ok", att, took);
        chk(att == 1, "R5 single attempt", att, 1);
        t_write(5, 8'd5, 0, 0, "R5 space equals length", att, took);
        t_write(0, 8'd0, 0, 0, "R5 zero length", att, took);
        t_write(3, 8'd8, 2, 0, "R6 retry success", att, took);
        chk(att == 3, "R6 attempts", att, 3);
        t_write(4, 8'd2, 0, 2, "R5 no space", att, took);
        chk(took >= TMO, "R6 timeout no space", took, TMO);
        t_write(2, 8'd8, 100000, 1, "R5 not ready", att, took);
        chk(took >= TMO && att > 1, "R6 timeout not ready", took, TMO);
        fail_left = 0;
        t_collide();
        t_masked();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end
endmodule